// File: doc/BRIEF.md
# Reconfigurable Register-Exchange Viterbi Decoder

This block decodes packets of a rate-1/2 convolutional code with hard-decision inputs. A packet's constraint length is chosen from 5, 7 or 9 by a select field that is sampled on the first symbol pair of the packet. Consecutive packets may use different lengths, and nothing has to be loaded between them. Each accepted symbol pair advances the trellis by one step. In that step every active state runs add-compare-select with Hamming branch metrics and modulo-compared 10-bit path metrics. Each state's survivor path is kept by register exchange, so no traceback is needed.

The states are grouped four to a lane. Only the lanes needed for the current trellis size (4, 16 or 64 of them) update their registers, and the remaining lanes stay frozen. Each butterfly reads two adjacent predecessor states and writes its two successors through a perfect-shuffle route. A packet is 64 payload pairs followed by K-1 zero-tail pairs. When the pair marked end-of-packet has been taken, the survivor of state 0 is streamed out bit by bit, and the input stays closed until the whole payload has been drained.

Top module: `vit_re_decoder`

## Requirements
- R1: Each symbol pair accepted while a packet is open advances the trellis one step; an error-free packet (64 payload pairs then K-1 zero-tail pairs) decodes to exactly its 64 payload bits.
- R2: The select `in_klen` is sampled with the start-of-packet pair: 0 selects K=5 (generators octal 23 and 35), 1 selects K=7 (171 and 133), 2 or 3 selects K=9 (753 and 561). `in_sym[1]` carries the first generator's output and `in_sym[0]` the second. A generator's most significant tap sits on the newest input bit.
- R3: A packet with up to two flipped code bits is still decoded exactly; the 10-bit path metrics wrap without normalization.
- R4: Output bits come in payload order, first bit first. `out_bit` and `out_last` hold steady while `out_valid` is high and `out_ready` is low. `out_last` is high only with the 64th bit, and `out_valid` drops after that bit is taken.
- R5: `in_ready` is low from the cycle after the end-of-packet pair is accepted until the last output bit is taken, and high again in the following cycle.
- R6: Symbol pairs offered while no packet is open and without start-of-packet are discarded: they produce no output and do not disturb the next packet.
- R7: Back-to-back packets that change K are each decoded correctly.
- R8: `out_valid` goes high in the cycle right after the end-of-packet pair is accepted.
- R9: Only the first 4, 16 or 64 lanes (K=5, 7, 9) update state; a smaller-K packet decodes correctly after a larger-K packet left stale state in the idle lanes.
- R10: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Symbol pair offered |
| in_ready | output | 1 | Decoder can take a symbol pair |
| in_sop | input | 1 | First pair of a packet |
| in_eop | input | 1 | Last (tail) pair of a packet |
| in_klen | input | 2 | Constraint-length select, sampled with in_sop |
| in_sym | input | 2 | Received hard-decision code bits |
| out_valid | output | 1 | Decoded bit available |
| out_ready | input | 1 | Consumer takes the decoded bit |
| out_bit | output | 1 | Decoded payload bit |
| out_last | output | 1 | Marks the 64th payload bit |

## Verification
The hardest case to reach from the ports is a small trellis running over lanes that still hold metrics and survivors from a larger one. The bench reaches it by interleaving packets so that K changes on every packet, with a K=5 packet directly after a K=9 packet. Payloads include all-zero, all-one, alternating and random patterns. Up to two code-bit errors are placed far apart in a packet. The output is stalled at random so that the hold rule is exercised.

// File: rtl/vit_pkg.sv
// Package: shared constants, the constraint-length select type and the
// code-pair function used by the butterflies.
// Assumes a maximum constraint length of 9; smaller trellises use a prefix
// of the state space.
package vit_pkg;

    localparam int KMAX    = 9;
    localparam int ST_W    = KMAX - 1;          // state index width
    localparam int NST     = 1 << ST_W;         // states at the largest K
    localparam int NBF     = NST / 2;           // butterflies
    localparam int BF_W    = ST_W - 1;
    localparam int LANE_ST = 4;                 // states per lane
    localparam int NLANE   = NST / LANE_ST;

    typedef enum logic [1:0] {KSEL5 = 2'd0, KSEL7 = 2'd1, KSEL9 = 2'd2} ksel_t;

    // Map the two-bit port field to a constraint length select.
    function automatic ksel_t ksel_decode(logic [1:0] f);
        case (f)
            2'd0:    return KSEL5;
            2'd1:    return KSEL7;
            default: return KSEL9;
        endcase
    endfunction

    // Constraint length as a number.
    function automatic logic [3:0] klen_of(ksel_t k);
        case (k)
            KSEL5:   return 4'd5;
            KSEL7:   return 4'd7;
            default: return 4'd9;
        endcase
    endfunction

    // Expected code pair for leaving state pred with input bit u.
    // The window is {u, pred}; the polynomial MSB taps u.
    function automatic logic [1:0] code_pair(ksel_t k, logic [ST_W-1:0] pred, logic u);
        logic [KMAX-1:0] w, g0, g1;
        case (k)
            KSEL5: begin
                w = {4'b0, u, pred[3:0]};
                g0 = 9'o023; g1 = 9'o035;
            end
            KSEL7: begin
                w = {2'b0, u, pred[5:0]};
                g0 = 9'o171; g1 = 9'o133;
            end
            default: begin
                w = {u, pred};
                g0 = 9'o753; g1 = 9'o561;
            end
        endcase
        return {^(w & g0), ^(w & g1)};
    endfunction

endpackage

// File: rtl/vit_bmu.sv
// Branch metric unit: Hamming distance from the received pair to each of the
// four possible code pairs. Assumes hard-decision input.
module vit_bmu (
    input  logic [1:0] sym,
    output logic [1:0] bm [4]
);
    // Distance to every candidate code pair.
    always_comb begin
        for (int c = 0; c < 4; c++) begin
            logic [1:0] d;
            d = sym ^ 2'(c);
            bm[c] = {1'b0, d[1]} + {1'b0, d[0]};
        end
    end
endmodule

// File: rtl/vit_acs_bfly.sv
// One add-compare-select butterfly. It reads the adjacent predecessor states
// 2J and 2J+1 and produces the successor with input 0 (lo) and with input 1
// (hi). Survivors move by register exchange: the winner's path is shifted and
// the input bit is appended at bit 0. Metrics are compared modulo 2^PM_W.
module vit_acs_bfly
    import vit_pkg::*;
#(
    parameter int PM_W = 10,
    parameter int SV_W = 72,
    parameter int J    = 0
) (
    input  ksel_t             ksel,
    input  logic [1:0]        bm [4],
    input  logic [PM_W-1:0]   pm_a,
    input  logic [PM_W-1:0]   pm_b,
    input  logic [SV_W-1:0]   sv_a,
    input  logic [SV_W-1:0]   sv_b,
    output logic [PM_W-1:0]   pm_lo,
    output logic [PM_W-1:0]   pm_hi,
    output logic [SV_W-1:0]   sv_lo,
    output logic [SV_W-1:0]   sv_hi
);
    localparam logic [ST_W-1:0] PA = ST_W'(2 * J);
    localparam logic [ST_W-1:0] PB = ST_W'(2 * J + 1);

    logic [PM_W-1:0] s_a0, s_b0, s_a1, s_b1;
    logic            pick_b0, pick_b1;
    logic [SV_W-1:0] w0, w1;

    // Modulo compare: a is better than b when a-b is negative.
    function automatic logic better(logic [PM_W-1:0] a, logic [PM_W-1:0] b);
        logic [PM_W-1:0] d;
        d = a - b;
        return d[PM_W-1];
    endfunction

    // Candidate sums for both successors.
    always_comb begin
        s_a0 = pm_a + PM_W'(bm[code_pair(ksel, PA, 1'b0)]);
        s_b0 = pm_b + PM_W'(bm[code_pair(ksel, PB, 1'b0)]);
        s_a1 = pm_a + PM_W'(bm[code_pair(ksel, PA, 1'b1)]);
        s_b1 = pm_b + PM_W'(bm[code_pair(ksel, PB, 1'b1)]);
    end

    // Compare-select; ties keep the even predecessor.
    always_comb begin
        pick_b0 = better(s_b0, s_a0);
        pick_b1 = better(s_b1, s_a1);
        pm_lo   = pick_b0 ? s_b0 : s_a0;
        pm_hi   = pick_b1 ? s_b1 : s_a1;
        w0      = pick_b0 ? sv_b : sv_a;
        w1      = pick_b1 ? sv_b : sv_a;
        sv_lo   = {w0[SV_W-2:0], 1'b0};
        sv_hi   = {w1[SV_W-2:0], 1'b1};
    end
endmodule

// File: rtl/vit_lane.sv
// Processing lane: holds metric and survivor registers for four states. It
// loads new values only when enabled; a disabled lane keeps its contents.
module vit_lane
    import vit_pkg::*;
#(
    parameter int PM_W = 10,
    parameter int SV_W = 72
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              en,
    input  logic [LANE_ST-1:0][PM_W-1:0]      pm_d,
    input  logic [LANE_ST-1:0][SV_W-1:0]      sv_d,
    output logic [LANE_ST-1:0][PM_W-1:0]      pm_q,
    output logic [LANE_ST-1:0][SV_W-1:0]      sv_q
);
    // State register update, gated by the lane enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_q <= '0;
            sv_q <= '0;
        end else if (en) begin
            pm_q <= pm_d;
            sv_q <= sv_d;
        end
    end

    // R9
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(pm_q) && $stable(sv_q)));
endmodule

// File: rtl/vit_ctrl.sv
// Packet controller: opens a packet on start-of-packet, latches the
// constraint length, issues one trellis step per accepted pair, then drains
// PAYLOAD_BITS decoded bits. Assumes the producer sends exactly the payload
// plus tail pairs per packet.
module vit_ctrl
    import vit_pkg::*;
#(
    parameter int PAYLOAD_BITS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic        in_eop,
    input  logic [1:0]  in_klen,
    input  logic        out_ready,
    output logic        in_ready,
    output logic        step,
    output logic        first,
    output ksel_t       ksel_eff,
    output ksel_t       ksel_q,
    output logic        out_valid,
    output logic        out_last,
    output logic [$clog2(PAYLOAD_BITS)-1:0] out_idx
);
    localparam int IDX_W = $clog2(PAYLOAD_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAYLOAD_BITS - 1);

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} st_t;
    st_t  st;
    logic accept;

    // Handshake and step qualification.
    always_comb begin
        in_ready  = (st != S_DRAIN);
        accept    = in_valid && in_ready;
        first     = accept && in_sop;
        step      = accept && (in_sop || st == S_RUN);
        ksel_eff  = first ? ksel_decode(in_klen) : ksel_q;
        out_valid = (st == S_DRAIN);
        out_last  = out_valid && (out_idx == LAST_IDX);
    end

    // Packet state, latched select and drain counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            ksel_q  <= KSEL5;
            out_idx <= '0;
        end else begin
            case (st)
                S_IDLE, S_RUN: begin
                    if (first) ksel_q <= ksel_decode(in_klen);
                    if (step) st <= in_eop ? S_DRAIN : S_RUN;
                    out_idx <= '0;
                end
                default: begin
                    if (out_ready) begin
                        out_idx <= out_idx + 1'b1;
                        if (out_idx == LAST_IDX) st <= S_IDLE;
                    end
                end
            endcase
        end
    end

    // R2
    klen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !first |=> $stable(ksel_q));
    // R6
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && in_valid && !in_sop) |=> !out_valid);
endmodule

// File: rtl/vit_re_decoder.sv
// Top: reconfigurable register-exchange Viterbi decoder for a rate-1/2 code
// with K of 5, 7 or 9. The butterflies read adjacent states and the results
// return through a perfect-shuffle route sized by the active K. Lanes beyond
// the active state count are gated off. Assumes a zero-tailed packet.
module vit_re_decoder
    import vit_pkg::*;
#(
    parameter int PAYLOAD_BITS = 64,
    parameter int PM_W         = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_sop,
    input  logic       in_eop,
    input  logic [1:0] in_klen,
    input  logic [1:0] in_sym,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_bit,
    output logic       out_last
);
    localparam int SV_W  = PAYLOAD_BITS + KMAX - 1;
    localparam int SV_IW = $clog2(SV_W);
    localparam int IDX_W = $clog2(PAYLOAD_BITS);
    localparam logic [PM_W-1:0] PM_BIG = PM_W'(1 << (PM_W - 2));

    logic        step, first;
    ksel_t       ksel_eff, ksel_q;
    logic [IDX_W-1:0] out_idx;
    logic [1:0]  bm [4];
    logic [ST_W:0]   nst_act;
    logic [ST_W-1:0] half;

    logic [PM_W-1:0] pm_cur [NST];
    logic [PM_W-1:0] pm_src [NST];
    logic [SV_W-1:0] sv_cur [NST];
    logic [SV_W-1:0] sv_src [NST];
    logic [PM_W-1:0] bf_pm_lo [NBF];
    logic [PM_W-1:0] bf_pm_hi [NBF];
    logic [SV_W-1:0] bf_sv_lo [NBF];
    logic [SV_W-1:0] bf_sv_hi [NBF];

    vit_ctrl #(.PAYLOAD_BITS(PAYLOAD_BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_klen(in_klen), .out_ready(out_ready),
        .in_ready(in_ready), .step(step), .first(first),
        .ksel_eff(ksel_eff), .ksel_q(ksel_q), .out_valid(out_valid),
        .out_last(out_last), .out_idx(out_idx)
    );

    vit_bmu u_bmu (.sym(in_sym), .bm(bm));

    // Active trellis size and shuffle distance for the current step.
    always_comb begin
        case (ksel_eff)
            KSEL5:   begin nst_act = (ST_W+1)'(16);  half = ST_W'(8);   end
            KSEL7:   begin nst_act = (ST_W+1)'(64);  half = ST_W'(32);  end
            default: begin nst_act = (ST_W+1)'(256); half = ST_W'(128); end
        endcase
    end

    // Step sources: the start pair uses the initial metrics and empty paths.
    for (genvar s = 0; s < NST; s++) begin : g_src
        assign pm_src[s] = !first ? pm_cur[s] : ((s == 0) ? '0 : PM_BIG);
        assign sv_src[s] = first ? '0 : sv_cur[s];
    end

    // Butterflies over adjacent state pairs.
    for (genvar j = 0; j < NBF; j++) begin : g_bf
        vit_acs_bfly #(.PM_W(PM_W), .SV_W(SV_W), .J(j)) u_bf (
            .ksel(ksel_eff), .bm(bm),
            .pm_a(pm_src[2*j]), .pm_b(pm_src[2*j+1]),
            .sv_a(sv_src[2*j]), .sv_b(sv_src[2*j+1]),
            .pm_lo(bf_pm_lo[j]), .pm_hi(bf_pm_hi[j]),
            .sv_lo(bf_sv_lo[j]), .sv_hi(bf_sv_hi[j])
        );
    end

    // Lanes with shuffle write-back routing and enable gating.
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic [LANE_ST-1:0][PM_W-1:0] pm_d, pm_q;
        logic [LANE_ST-1:0][SV_W-1:0] sv_d, sv_q;
        logic                         en;

        // Route each of this lane's states from its butterfly output.
        always_comb begin
            for (int i = 0; i < LANE_ST; i++) begin
                logic [ST_W-1:0] s, r;
                s = ST_W'(LANE_ST * l + i);
                r = s - half;
                if (s < half) begin
                    pm_d[i] = bf_pm_lo[s[BF_W-1:0]];
                    sv_d[i] = bf_sv_lo[s[BF_W-1:0]];
                end else begin
                    pm_d[i] = bf_pm_hi[r[BF_W-1:0]];
                    sv_d[i] = bf_sv_hi[r[BF_W-1:0]];
                end
            end
        end

        assign en = step && ((ST_W+1)'(LANE_ST * l) < nst_act);

        vit_lane #(.PM_W(PM_W), .SV_W(SV_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .en(en),
            .pm_d(pm_d), .sv_d(sv_d), .pm_q(pm_q), .sv_q(sv_q)
        );

        for (genvar i = 0; i < LANE_ST; i++) begin : g_out
            assign pm_cur[LANE_ST*l+i] = pm_q[i];
            assign sv_cur[LANE_ST*l+i] = sv_q[i];
        end
    end

    // Select the payload bit from state 0's survivor, oldest bit first.
    always_comb begin
        logic [SV_IW-1:0] pos;
        pos = SV_IW'(PAYLOAD_BITS - 2) + SV_IW'(klen_of(ksel_q)) - SV_IW'(out_idx);
        out_bit = sv_cur[0][pos];
    end

    // R8
    eop_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && in_eop) |=> out_valid);
    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));
    // R5
    last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));
    // R5
    drain_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
endmodule

// File: tb/vit_re_decoder_tb.sv
module vit_re_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PB = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, out_ready = 1'b0;
    logic [1:0] in_klen = 2'd0, in_sym = 2'd0;
    logic in_ready, out_valid, out_bit, out_last;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vit_re_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sop(in_sop), .in_eop(in_eop), .in_klen(in_klen), .in_sym(in_sym),
        .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
        .out_last(out_last)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int klen_num(logic [1:0] f);
        return (f == 2'd0) ? 5 : (f == 2'd1) ? 7 : 9;
    endfunction

    // Encode, inject errors at flat code-bit positions (negative = none), send.
    task automatic send_pkt(logic [1:0] kf, logic [PB-1:0] pay, int e1, int e2);
        int k = klen_num(kf);
        int t = PB + k - 1;
        logic [8:0] g0, g1, sr, w;
        logic [1:0] syms [PB+8];
        g0 = (k == 5) ? 9'o023 : (k == 7) ? 9'o171 : 9'o753;
        g1 = (k == 5) ? 9'o035 : (k == 7) ? 9'o133 : 9'o561;
        sr = '0;
        for (int i = 0; i < t; i++) begin
            logic u;
            u = (i < PB) ? pay[i] : 1'b0;
            w = sr | (9'(u) << (k - 1));
            syms[i] = {^(w & g0), ^(w & g1)};
            sr = w >> 1;
        end
        if (e1 >= 0) syms[e1/2][e1%2] = ~syms[e1/2][e1%2];
        if (e2 >= 0) syms[e2/2][e2%2] = ~syms[e2/2][e2%2];
        for (int i = 0; i < t; i++) begin
            do begin
                @(negedge clk);
                in_valid = 1'b1; in_sym = syms[i];
                in_sop = (i == 0); in_eop = (i == t - 1); in_klen = kf;
            end while (!in_ready);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        chk("R8", "out_valid after eop", out_valid, 1);
        chk("R5", "in_ready closed", in_ready, 0);
    endtask

    task automatic recv_pkt(string req, logic [PB-1:0] exp, bit stall);
        logic [PB-1:0] got = '0;
        int n = 0;
        bit pst = 0;
        logic pbit = 0, plast = 0;
        while (n < PB) begin
            logic rdy;
            @(negedge clk);
            if (pst) begin
                chk("R4", "bit held in stall", {out_bit, out_last}, {pbit, plast});
            end
            rdy = stall ? ($urandom % 3 != 0) : 1'b1;
            out_ready = rdy;
            if (out_valid && rdy) begin
                got[n] = out_bit;
                if (out_last != (n == PB - 1))
                    chk("R4", "last flag position", out_last, (n == PB - 1));
                n++;
                pst = 0;
            end else begin
                pst = out_valid; pbit = out_bit; plast = out_last;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        chk(req, "decoded payload", got, exp);
        chk("R5", "in_ready reopened", in_ready, 1);
        chk("R4", "out_valid dropped", out_valid, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        chk("R10", "out_valid after reset", out_valid, 0);
        chk("R10", "in_ready after reset", in_ready, 1);

        // R6: stray pairs while idle
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sym = 2'(i + 1); in_sop = 1'b0; in_eop = (i == 2);
        end
        @(negedge clk);
        in_valid = 1'b0; in_eop = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6", "no output from stray pairs", out_valid, 0);
        begin
            logic [PB-1:0] p = {$urandom, $urandom};
            send_pkt(2'd1, p, -1, -1);
            recv_pkt("R6", p, 0);
        end

        // Sweep: K changes each packet (R7); K=5 follows K=9 (R9).
        for (int c = 0; c < 6; c++) begin
            for (int kk = 0; kk < 3; kk++) begin
                logic [PB-1:0] p;
                logic [1:0] kf;
                int e1, e2, t;
                string req;
                kf = (kk == 2 && c == 1) ? 2'd3 : 2'(kk);
                t = 2 * (PB + klen_num(kf) - 1);
                case (c)
                    0: p = '0;
                    1: p = '1;
                    2: p = {32{2'b10}};
                    default: p = {$urandom, $urandom};
                endcase
                e1 = -1; e2 = -1;
                if (c == 2 || c == 3) e1 = int'($urandom % 20) + 3;
                if (c == 3 || c == 4) begin
                    e1 = int'($urandom % 30) + 5;
                    e2 = e1 + t / 2 + int'($urandom % 20);
                end
                if (e1 >= 0 || e2 >= 0) req = "R3";
                else if (kk == 0 && c > 0) req = "R9";
                else if (c == 1 && kk == 2) req = "R2";
                else if (c > 0) req = "R7";
                else req = "R1";
                send_pkt(kf, p, e1, e2);
                recv_pkt(req, p, (c % 2) == 1);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule